// File: doc/BRIEF.md
# CPU Clock and Standby Controller

This block generates the machine-cycle enable for a small processor core. The enable is derived from one of two oscillator tick streams: a fast main-clock tick or a slow 32.768 kHz subsystem tick. Two small registers control it. A speed register picks the machine-cycle length on the main clock: 4, 8 or 64 main periods. A source register switches the core onto the subsystem clock, which gives a fixed 4-period cycle, and can also shut the main oscillator off. A change to either register is applied only when the current machine cycle completes, so a cycle in progress is never cut short.

The block also sequences the two standby modes. HALT gates the cycle enable and leaves both oscillators running. STOP is accepted only while the core runs from the main clock; it turns the main oscillator off. Either mode is left through an enabled-interrupt wake signal. Leaving STOP, and coming out of reset, passes through a settling wait of 2^SETTLE_LOG2 main ticks before cycles resume. The default of 2^17 corresponds to about 31.3 ms at 4.19 MHz. All logic runs on one system clock; the oscillator ticks arrive as single-clock enables.

Top module: `cpu_clkctl`

## Requirements
- R1: While reset is held and right after it, mode is WAIT, both registers read zero, the main clock is the active source, and cpu_cyc and osc_off are 0.
- R2: After reset, mode goes from WAIT to RUN on exactly the 2^SETTLE_LOG2-th main tick. Subsystem ticks do not advance the wait.
- R3: On the main clock the cycle length is chosen by speed-register bits [1:0]: 11 gives 4 main ticks, 10 gives 8, and 00 or 01 give 64. Bits [3:2] are stored and read back but have no effect.
- R4: Source-register bit 0 set makes the subsystem clock the source, with a cycle of 4 subsystem ticks; main ticks then produce no cycles. While the subsystem clock is active, bit 3 drives osc_off high. Bits 2:1 always read 0.
- R5: New speed and source settings take effect only at the end of the cycle in progress. A cycle already begun completes with its old length and source.
- R6: halt_req in RUN enters HALT from either source. In HALT there are no cpu_cyc pulses and osc_off is unchanged. wake returns to RUN, and the next cycle counts from zero.
- R7: stop_req in RUN with the main clock active enters STOP: osc_off goes high and speed-register bits [1:0] are cleared. While the subsystem clock is active, stop_req is ignored.
- R8: wake in STOP enters WAIT with osc_off low. RUN follows on exactly the 2^SETTLE_LOG2-th main tick.
- R9: Requests that do not apply in the current mode are ignored: wake in RUN or WAIT, halt_req and stop_req in HALT, STOP or WAIT.
- R10: When halt_req and stop_req arrive together in RUN on the main clock, STOP is taken.
- R11: status bits [3:0] give the speed register, [7:4] the source register, [8] is 1 when the subsystem clock is the active source, and [10:9] give the mode (RUN=0, HALT=1, STOP=2, WAIT=3).
- R12: cpu_cyc is a one-clock pulse in the clock after the tick that completes a cycle, and it is only raised in RUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| main_tick | input | 1 | One-clock enable per main oscillator period |
| sub_tick | input | 1 | One-clock enable per subsystem oscillator period |
| spd_we | input | 1 | Write strobe for the speed register |
| spd_wdata | input | 4 | Speed register write data |
| src_we | input | 1 | Write strobe for the source register |
| src_wdata | input | 4 | Source register write data |
| halt_req | input | 1 | Request to enter HALT |
| stop_req | input | 1 | Request to enter STOP |
| wake | input | 1 | Enabled interrupt request that ends standby |
| cpu_cyc | output | 1 | Machine-cycle enable pulse |
| osc_off | output | 1 | Main oscillator disable |
| status | output | 11 | Mode, active source and register contents |

## Verification
The hardest situation to reach is a register change that lands in the middle of a cycle. It must leave the cycle in progress at its old length and then switch length or source at the boundary. The bench creates this by stepping single ticks from a known boundary, writing in between ticks, and counting ticks to each following pulse. Standby is checked on both sources, including with the main oscillator already disabled. The settling wait is counted tick by tick with a reduced SETTLE_LOG2, with subsystem ticks and stray requests injected while it runs.

// File: rtl/cpu_clkctl_pkg.sv
package cpu_clkctl_pkg;

    typedef enum logic [1:0] {
        MODE_RUN  = 2'd0,
        MODE_HALT = 2'd1,
        MODE_STOP = 2'd2,
        MODE_WAIT = 2'd3
    } mode_e;

    localparam logic [1:0] SPD_FAST = 2'b11;
    localparam logic [1:0] SPD_MID  = 2'b10;

    localparam logic [3:0] SRC_KEEP_MASK = 4'b1001;

endpackage

// File: rtl/cpu_clkctl_regs.sv
module cpu_clkctl_regs
    import cpu_clkctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       spd_we,
    input  logic [3:0] spd_wdata,
    input  logic       src_we,
    input  logic [3:0] src_wdata,
    input  logic       stop_take,
    output logic [3:0] spd_q,
    output logic [3:0] src_q
);

    typedef struct packed {
        logic [3:0] spd;
        logic [3:0] src;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (spd_we) begin
            r_d.spd = spd_wdata;
        end
        if (src_we) begin
            r_d.src = src_wdata & SRC_KEEP_MASK;
        end
        if (stop_take) begin
            r_d.spd[1:0] = 2'b00;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign spd_q = r_q.spd;
    assign src_q = r_q.src;

    // R7: entering STOP leaves the two low speed bits cleared
    p_stop_clears_spd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stop_take |=> (spd_q[1:0] == 2'b00));

    // R3: the speed register only moves on a write or a STOP entry
    p_spd_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!spd_we && !stop_take) |=> $stable(spd_q));

endmodule

// File: rtl/cpu_clkctl_div.sv
module cpu_clkctl_div
    import cpu_clkctl_pkg::*;
#(
    parameter int MAIN_FAST = 4,
    parameter int MAIN_MID  = 8,
    parameter int MAIN_SLOW = 64,
    parameter int SUB_DIV   = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       main_tick,
    input  logic       sub_tick,
    input  logic [1:0] spd_lo,
    input  logic       src_sel,
    output logic       cyc,
    output logic       act_sub
);

    localparam int MAX_AB  = (MAIN_FAST > MAIN_MID) ? MAIN_FAST : MAIN_MID;
    localparam int MAX_CD  = (MAIN_SLOW > SUB_DIV) ? MAIN_SLOW : SUB_DIV;
    localparam int MAX_LEN = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int CNT_W   = (MAX_LEN > 2) ? $clog2(MAX_LEN) : 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             sub;
        logic [1:0]       spd;
        logic             cyc;
    } div_t;

    div_t s_d, s_q;

    function automatic logic [CNT_W-1:0] last_of(input logic sub, input logic [1:0] spd);
        if (sub) begin
            return CNT_W'(SUB_DIV - 1);
        end
        case (spd)
            SPD_FAST: return CNT_W'(MAIN_FAST - 1);
            SPD_MID:  return CNT_W'(MAIN_MID - 1);
            default:  return CNT_W'(MAIN_SLOW - 1);
        endcase
    endfunction

    logic             tick_sel;
    logic [CNT_W-1:0] last_cnt;

    always_comb begin
        tick_sel = s_q.sub ? sub_tick : main_tick;
        last_cnt = last_of(s_q.sub, s_q.spd);
        s_d      = s_q;
        s_d.cyc  = 1'b0;
        if (!run) begin
            s_d.cnt = '0;
            s_d.sub = src_sel;
            s_d.spd = spd_lo;
        end else if (tick_sel) begin
            if (s_q.cnt == last_cnt) begin
                s_d.cyc = 1'b1;
                s_d.cnt = '0;
                s_d.sub = src_sel;
                s_d.spd = spd_lo;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cyc     = s_q.cyc;
    assign act_sub = s_q.sub;

    // R12: a cycle pulse only follows a clock spent in RUN
    p_cyc_in_run_r12: assert property (@(posedge clk) disable iff (!rst_n)
        cyc |-> $past(run));

    // R12: the pulse is one clock wide
    p_cyc_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
        cyc |=> !cyc);

    // R5: while running, the source only changes at a cycle boundary
    p_switch_at_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run) && (act_sub != $past(act_sub))) |-> cyc);

endmodule

// File: rtl/cpu_clkctl_seq.sv
module cpu_clkctl_seq
    import cpu_clkctl_pkg::*;
#(
    parameter int SETTLE_LOG2 = 17
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  main_tick,
    input  logic  halt_req,
    input  logic  stop_req,
    input  logic  wake,
    input  logic  act_sub,
    output mode_e mode,
    output logic  stop_take
);

    typedef struct packed {
        mode_e                  mode;
        logic [SETTLE_LOG2-1:0] wcnt;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        stop_take = (s_q.mode == MODE_RUN) && stop_req && !act_sub;
        case (s_q.mode)
            MODE_RUN: begin
                if (stop_take) begin
                    s_d.mode = MODE_STOP;
                end else if (halt_req) begin
                    s_d.mode = MODE_HALT;
                end
            end
            MODE_HALT: begin
                if (wake) begin
                    s_d.mode = MODE_RUN;
                end
            end
            MODE_STOP: begin
                if (wake) begin
                    s_d.mode = MODE_WAIT;
                    s_d.wcnt = '0;
                end
            end
            default: begin
                if (main_tick) begin
                    if (&s_q.wcnt) begin
                        s_d.mode = MODE_RUN;
                        s_d.wcnt = '0;
                    end else begin
                        s_d.wcnt = s_q.wcnt + 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.mode <= MODE_WAIT;
            s_q.wcnt <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign mode = s_q.mode;

    // R6: HALT is only left on a wake request
    p_halt_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(s_q.mode) == MODE_HALT) && (s_q.mode != MODE_HALT)) |-> $past(wake));

    // R7: STOP is only entered with the main clock active
    p_stop_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((s_q.mode == MODE_STOP) && ($past(s_q.mode) != MODE_STOP)) |-> !$past(act_sub));

    // R8: STOP always leaves through the settling wait
    p_stop_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(s_q.mode) == MODE_STOP) && (s_q.mode != MODE_STOP)) |-> (s_q.mode == MODE_WAIT));

    // R2: the settling count advances only on main ticks
    p_wait_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((s_q.mode == MODE_WAIT) && ($past(s_q.mode) == MODE_WAIT) && (s_q.wcnt != $past(s_q.wcnt)))
        |-> $past(main_tick));

endmodule

// File: rtl/cpu_clkctl.sv
module cpu_clkctl
    import cpu_clkctl_pkg::*;
#(
    parameter int MAIN_FAST   = 4,
    parameter int MAIN_MID    = 8,
    parameter int MAIN_SLOW   = 64,
    parameter int SUB_DIV     = 4,
    parameter int SETTLE_LOG2 = 17
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        main_tick,
    input  logic        sub_tick,
    input  logic        spd_we,
    input  logic [3:0]  spd_wdata,
    input  logic        src_we,
    input  logic [3:0]  src_wdata,
    input  logic        halt_req,
    input  logic        stop_req,
    input  logic        wake,
    output logic        cpu_cyc,
    output logic        osc_off,
    output logic [10:0] status
);

    logic [3:0] spd_q;
    logic [3:0] src_q;
    logic       stop_take;
    logic       act_sub;
    mode_e      mode;

    cpu_clkctl_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .spd_we    (spd_we),
        .spd_wdata (spd_wdata),
        .src_we    (src_we),
        .src_wdata (src_wdata),
        .stop_take (stop_take),
        .spd_q     (spd_q),
        .src_q     (src_q)
    );

    cpu_clkctl_div #(
        .MAIN_FAST (MAIN_FAST),
        .MAIN_MID  (MAIN_MID),
        .MAIN_SLOW (MAIN_SLOW),
        .SUB_DIV   (SUB_DIV)
    ) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (mode == MODE_RUN),
        .main_tick (main_tick),
        .sub_tick  (sub_tick),
        .spd_lo    (spd_q[1:0]),
        .src_sel   (src_q[0]),
        .cyc       (cpu_cyc),
        .act_sub   (act_sub)
    );

    cpu_clkctl_seq #(
        .SETTLE_LOG2 (SETTLE_LOG2)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .main_tick (main_tick),
        .halt_req  (halt_req),
        .stop_req  (stop_req),
        .wake      (wake),
        .act_sub   (act_sub),
        .mode      (mode),
        .stop_take (stop_take)
    );

    assign osc_off = (mode == MODE_STOP) || (act_sub && src_q[3]);
    assign status  = {mode, act_sub, src_q, spd_q};

    // R4: the main oscillator is only shut down in STOP or on the subsystem clock
    p_osc_off_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_off && (status[10:9] != 2'd2)) |-> status[8]);

endmodule

// File: tb/cpu_clkctl_tb_top.sv
`timescale 1ns/1ps
module cpu_clkctl_tb_top;

    localparam int SL2    = 5;
    localparam int SETTLE = 1 << SL2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        main_tick = 1'b0;
    logic        sub_tick = 1'b0;
    logic        spd_we = 1'b0;
    logic [3:0]  spd_wdata = 4'd0;
    logic        src_we = 1'b0;
    logic [3:0]  src_wdata = 4'd0;
    logic        halt_req = 1'b0;
    logic        stop_req = 1'b0;
    logic        wake = 1'b0;
    logic        cpu_cyc;
    logic        osc_off;
    logic [10:0] status;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    cpu_clkctl #(.SETTLE_LOG2(SL2)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .main_tick (main_tick),
        .sub_tick  (sub_tick),
        .spd_we    (spd_we),
        .spd_wdata (spd_wdata),
        .src_we    (src_we),
        .src_wdata (src_wdata),
        .halt_req  (halt_req),
        .stop_req  (stop_req),
        .wake      (wake),
        .cpu_cyc   (cpu_cyc),
        .osc_off   (osc_off),
        .status    (status)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_len(input logic [3:0] v);
        if (v[1:0] == 2'b11) return 4;
        if (v[1:0] == 2'b10) return 8;
        return 64;
    endfunction

    task automatic tick(input bit s);
        main_tick = !s;
        sub_tick  = s;
        @(negedge clk);
        main_tick = 1'b0;
        sub_tick  = 1'b0;
    endtask

    task automatic count_cyc(input bit s, input int n, output int c);
        c = 0;
        for (int i = 0; i < n; i++) begin
            tick(s);
            if (cpu_cyc) c++;
        end
    endtask

    task automatic measure(input bit s, output int n);
        n = 0;
        for (int i = 0; i < 200; i++) begin
            tick(s);
            n++;
            if (cpu_cyc) break;
        end
    endtask

    task automatic settle(output int n);
        n = 0;
        for (int i = 0; i < 10000; i++) begin
            tick(1'b0);
            n++;
            if (status[10:9] == 2'd0) break;
        end
    endtask

    task automatic wr_spd(input logic [3:0] v);
        spd_we = 1'b1; spd_wdata = v;
        @(negedge clk);
        spd_we = 1'b0;
    endtask

    task automatic wr_src(input logic [3:0] v);
        src_we = 1'b1; src_wdata = v;
        @(negedge clk);
        src_we = 1'b0;
    endtask

    task automatic pulse(input bit h, input bit s, input bit w);
        halt_req = h; stop_req = s; wake = w;
        @(negedge clk);
        halt_req = 1'b0; stop_req = 1'b0; wake = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int n;
        int c;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 status", int'(status), 11'h600);
        chk("R1 cpu_cyc", int'(cpu_cyc), 0);
        chk("R1 osc_off", int'(osc_off), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", int'(status), 11'h600);

        // R2 subsystem ticks do not advance the wait
        count_cyc(1'b1, 10, c);
        chk("R2 mode after sub ticks", int'(status[10:9]), 3);
        settle(n);
        chk("R2 settle ticks", n, SETTLE);

        // R5 mid-cycle speed change finishes old cycle
        count_cyc(1'b0, 3, c);
        chk("R12 no pulse early", c, 0);
        wr_spd(4'h3);
        measure(1'b0, n);
        chk("R5 old cycle remainder", n, 61);
        measure(1'b0, n);
        chk("R3 fast cycle", n, 4);

        // R3 / R11 sweep of speed register
        for (int v = 0; v < 16; v++) begin
            wr_spd(4'(v));
            chk("R11 speed readback", int'(status[3:0]), v);
            measure(1'b0, n);
            measure(1'b0, n);
            chk("R3 cycle length", n, exp_len(4'(v)));
        end

        // R4 / R11 source register readback sweep
        for (int v = 0; v < 16; v++) begin
            wr_src(4'(v));
            chk("R4 source readback", int'(status[7:4]), v & 9);
        end
        wr_src(4'h1);
        chk("R5 source not yet switched", int'(status[8]), 0);
        measure(1'b0, n);
        chk("R4 sub active", int'(status[8]), 1);
        measure(1'b1, n);
        chk("R4 sub cycle", n, 4);
        count_cyc(1'b0, 10, c);
        chk("R4 main ticks ignored on sub", c, 0);
        chk("R4 osc on", int'(osc_off), 0);
        wr_src(4'hF);
        chk("R4 osc off on sub", int'(osc_off), 1);

        // R6 HALT on subsystem clock
        count_cyc(1'b1, 2, c);
        pulse(1'b1, 1'b0, 1'b0);
        chk("R6 halt mode sub", int'(status[10:9]), 1);
        chk("R6 osc unchanged", int'(osc_off), 1);
        count_cyc(1'b1, 8, c);
        chk("R6 no cycles in halt", c, 0);
        pulse(1'b0, 1'b0, 1'b1);
        chk("R6 wake to run", int'(status[10:9]), 0);
        measure(1'b1, n);
        chk("R6 fresh cycle sub", n, 4);

        // R7 STOP ignored on sub; R9 wake in RUN ignored
        pulse(1'b0, 1'b1, 1'b0);
        chk("R7 stop ignored on sub", int'(status[10:9]), 0);
        chk("R7 spd kept on sub", int'(status[3:0]), 15);
        pulse(1'b0, 1'b0, 1'b1);
        chk("R9 wake in run", int'(status[10:9]), 0);

        // back to main
        wr_src(4'h0);
        chk("R4 osc on after clear", int'(osc_off), 0);
        measure(1'b1, n);
        chk("R5 main active at edge", int'(status[8]), 0);
        measure(1'b0, n);
        chk("R3 main fast again", n, 4);

        // R6 HALT on main, R9 stop in HALT ignored
        wr_spd(4'h2);
        measure(1'b0, n);
        count_cyc(1'b0, 3, c);
        pulse(1'b1, 1'b0, 1'b0);
        chk("R6 halt mode main", int'(status[10:9]), 1);
        chk("R6 osc on in halt", int'(osc_off), 0);
        pulse(1'b0, 1'b1, 1'b0);
        chk("R9 stop in halt", int'(status[10:9]), 1);
        chk("R9 spd kept in halt", int'(status[3:0]), 2);
        count_cyc(1'b0, 10, c);
        chk("R6 no cycles halt main", c, 0);
        pulse(1'b0, 1'b0, 1'b1);
        measure(1'b0, n);
        chk("R6 fresh cycle main", n, 8);

        // R10 / R7 / R8 STOP path
        wr_spd(4'hF);
        measure(1'b0, n);
        pulse(1'b1, 1'b1, 1'b0);
        chk("R10 stop wins", int'(status[10:9]), 2);
        chk("R7 osc off", int'(osc_off), 1);
        chk("R7 spd low cleared", int'(status[3:0]), 12);
        count_cyc(1'b0, 5, c);
        chk("R7 no cycles in stop", c, 0);
        pulse(1'b1, 1'b0, 1'b0);
        chk("R9 halt in stop", int'(status[10:9]), 2);
        pulse(1'b0, 1'b0, 1'b1);
        chk("R8 wait after wake", int'(status[10:9]), 3);
        chk("R8 osc on in wait", int'(osc_off), 0);
        pulse(1'b1, 1'b0, 1'b1);
        chk("R9 halt and wake in wait", int'(status[10:9]), 3);
        settle(n);
        chk("R8 settle ticks", n, SETTLE);
        measure(1'b0, n);
        chk("R8 slow after stop", n, 64);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule